// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block is the half-duplex, clocked-shift mode of a small microcontroller serial unit. One pin carries data in both directions and a second pin drives the shift clock to an external shift register. Every transfer moves eight data bits, least significant bit first, at one bit per machine cycle. A machine cycle is six states of two phases each. A free-running phase counter defines it, and every internal action is tied to a particular state and phase.

Software starts a transmit by writing a byte to the data buffer. It starts a receive by setting the receive enable while the receive flag is clear. The end of a frame is found by a marker bit that travels through the shift register, not by a bit counter. At the end of each direction the block raises a flag, and the flag stays up until software pulses the matching clear input. A fast mode halves the machine cycle, so that each clock covers both phases of a state.

Top module: `sync_shift_port`

## Requirements
- R1: While `rst` is high and after it is released: `sclk_o`=1, `data_o`=1, `data_oe`=1, `tx_flag`=0, `rx_flag`=0, `rx_data`=0, and the phase counter holds index 0.
- R2: Phase index i runs 0..11. Index 2(s-1) is state s phase 1 and index 2(s-1)+1 is state s phase 2. With `fast_mode`=0 the index steps by one each clock and wraps from 11 to 0. With `fast_mode`=1 it steps by two, so one machine cycle takes 6 clocks and both phases of a state are handled in the same clock.
- R3: A transmitted frame gives exactly 8 rising edges on `sclk_o`. During rising edge k (k=0..7), `data_o` equals bit k of the written byte.
- R4: Call the machine cycle of the clock that samples `buf_wr` cycle 0. The byte is accepted at the first state 6 phase 2 at or after that clock. `data_o` starts carrying bit 0 at state 6 phase 2 of cycle 1. `tx_flag` rises at state 1 phase 1 of cycle 10.
- R5: During a transfer, `sclk_o` is low for phase indices 4..9 (states 3 to 5) and high otherwise. Outside a transfer, `sclk_o` and `data_o` are 1.
- R6: A `buf_wr` that arrives while a transmit or receive is in progress has no effect. No further frame is sent and `tx_flag` does not change.
- R7: Call the machine cycle in which the block first samples `rx_en`=1 with `rx_flag`=0 and no transfer in progress cycle 0. A receive starts then. The receive register is loaded at state 6 phase 2 of cycle 1, and receiving starts at state 1 phase 1 of cycle 2. `data_oe` is 0 while receiving.
- R8: While receiving, `data_i` is sampled at state 5 phase 2 of each cycle, and the first sample becomes `rx_data[0]`. `rx_data` holds the 8 samples and `rx_flag` rises at state 1 phase 1 of cycle 10.
- R9: `tx_flag` and `rx_flag` stay set until the pulse on `tx_flag_clr` or `rx_flag_clr`. Clearing `rx_flag` while `rx_en`=1 starts a new receive.
- R10: While `rx_flag`=1, no receive starts and `sclk_o` stays high, even with `rx_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock |
| rst | input | 1 | Synchronous active-high reset |
| fast_mode | input | 1 | 1: two phases per clock (6-clock machine cycle) |
| buf_wr | input | 1 | Write strobe of the transmit buffer |
| buf_wdata | input | 8 | Byte to transmit |
| rx_en | input | 1 | Receive enable |
| tx_flag_clr | input | 1 | Clears `tx_flag` |
| rx_flag_clr | input | 1 | Clears `rx_flag` |
| data_i | input | 1 | Data pin input value |
| data_o | output | 1 | Data pin drive value |
| data_oe | output | 1 | Data pin output enable (0 while receiving) |
| sclk_o | output | 1 | Shift clock pin |
| tx_flag | output | 1 | Transmit-done flag |
| rx_flag | output | 1 | Receive-done flag |
| rx_data | output | 8 | Last received byte |

## Verification
If the marker bit is lost or duplicated, the frame length on `sclk_o` changes. That shows up as a missing or extra clock edge within one machine cycle of the expected end, and as a flag that rises at the wrong clock. If the phase counter or its strobes are wrong, the shift clock low window moves away from states 3 to 5 in the very first transfer cycle. If the receive register is reversed or started at the wrong point, `rx_data` shows a reversed or shifted byte when `rx_flag` rises. If a state machine stays busy when it should not, it shows as a later write or receive start producing no shift clock at all.

// File: rtl/sp_pkg.sv
package sp_pkg;

    localparam int DATA_W   = 8;
    localparam int PH_COUNT = 12;
    localparam int PH_W     = $clog2(PH_COUNT);

    typedef logic [PH_W-1:0] phase_t;

    // phase index = 2*(state-1) + (phase-1)
    localparam phase_t PH_S1P1 = phase_t'(0);
    localparam phase_t PH_S3P1 = phase_t'(4);
    localparam phase_t PH_S5P2 = phase_t'(9);
    localparam phase_t PH_S6P1 = phase_t'(10);
    localparam phase_t PH_S6P2 = phase_t'(11);

    typedef struct packed {
        logic s1p1;
        logic s3p1;
        logic s5p2;
        logic s6p1;
        logic s6p2;
        logic clk_low;
    } strobes_t;

    typedef enum logic [2:0] {
        TX_IDLE, TX_PEND, TX_WAIT, TX_SEND, TX_FINISH
    } tx_state_t;

    typedef enum logic [2:0] {
        RX_IDLE, RX_REQ, RX_ARM, RX_LOADED, RX_RUN, RX_FINISH
    } rx_state_t;

    // In fast mode both phases of a state share one clock (even index).
    function automatic logic at_phase(phase_t ph, phase_t idx, logic fast);
        if (fast)
            return ph == {idx[PH_W-1:1], 1'b0};
        return ph == idx;
    endfunction

    function automatic logic [DATA_W-1:0] bit_reverse(logic [DATA_W-1:0] v);
        logic [DATA_W-1:0] r;
        for (int i = 0; i < DATA_W; i++)
            r[i] = v[DATA_W-1-i];
        return r;
    endfunction

endpackage

// File: rtl/sp_timebase.sv
module sp_timebase
    import sp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     fast,
    output strobes_t ev
);

    phase_t ph_q;
    phase_t ph_step;

    always_comb begin
        if (fast)
            ph_step = {ph_q[PH_W-1:1], 1'b0} + phase_t'(2);
        else
            ph_step = ph_q + phase_t'(1);
        if (ph_step >= phase_t'(PH_COUNT))
            ph_step = '0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            ph_q <= PH_S1P1;
        else
            ph_q <= ph_step;
    end

    always_comb begin
        ev.s1p1    = at_phase(ph_q, PH_S1P1, fast);
        ev.s3p1    = at_phase(ph_q, PH_S3P1, fast);
        ev.s5p2    = at_phase(ph_q, PH_S5P2, fast);
        ev.s6p1    = at_phase(ph_q, PH_S6P1, fast);
        ev.s6p2    = at_phase(ph_q, PH_S6P2, fast);
        ev.clk_low = (ph_q >= PH_S3P1) && (ph_q <= PH_S5P2);
    end

endmodule

// File: rtl/sp_tx.sv
module sp_tx
    import sp_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         s1p1,
    input  logic         s6p2,
    input  logic         wr,
    input  logic [W-1:0] wr_data,
    input  logic         rx_busy,
    input  logic         flag_clr,
    output logic         sending,
    output logic         line,
    output logic         busy,
    output logic         flag
);

    localparam logic [W-1:0] MARKER_ONLY = W'(1);

    tx_state_t    st;
    logic [W:0]   sh;
    logic [W-1:0] hold_q;
    logic         last_shift;

    // marker just above the MSB with only zeros above it
    assign last_shift = (sh[W:1] == MARKER_ONLY);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= TX_IDLE;
            sh     <= '1;
            hold_q <= '0;
            flag   <= 1'b0;
        end else begin
            if (flag_clr)
                flag <= 1'b0;
            case (st)
                TX_IDLE: begin
                    if (wr && !rx_busy) begin
                        hold_q <= wr_data;
                        if (s6p2) begin
                            sh <= {1'b1, wr_data};
                            st <= TX_WAIT;
                        end else begin
                            st <= TX_PEND;
                        end
                    end
                end
                TX_PEND: begin
                    if (s6p2) begin
                        sh <= {1'b1, hold_q};
                        st <= TX_WAIT;
                    end
                end
                TX_WAIT: begin
                    if (s6p2)
                        st <= TX_SEND;
                end
                TX_SEND: begin
                    if (s6p2) begin
                        sh <= {1'b0, sh[W:1]};
                        if (last_shift)
                            st <= TX_FINISH;
                    end
                end
                TX_FINISH: begin
                    if (s1p1) begin
                        st   <= TX_IDLE;
                        flag <= 1'b1;
                    end
                end
                default: st <= TX_IDLE;
            endcase
        end
    end

    assign sending = (st == TX_SEND) || (st == TX_FINISH);
    assign line    = sending ? sh[0] : 1'b1;
    assign busy    = (st != TX_IDLE);

    // R4
    tx_flag_s1p1_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(s1p1));

    // R3
    tx_marker_chk: assert property (@(posedge clk) disable iff (rst)
        (st == TX_SEND) |-> (sh != '0));

    // R6
    tx_no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        (st == TX_SEND) |-> !rx_busy);

endmodule

// File: rtl/sp_rx.sv
module sp_rx
    import sp_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         s1p1,
    input  logic         s5p2,
    input  logic         s6p2,
    input  logic         enable,
    input  logic         din,
    input  logic         tx_busy,
    input  logic         tx_req,
    input  logic         flag_clr,
    output logic         receiving,
    output logic         busy,
    output logic         flag,
    output logic [W-1:0] data
);

    rx_state_t    st;
    logic [W-1:0] sh;
    logic         smp_q;
    logic [W-1:0] shifted;

    assign shifted = {sh[W-2:0], smp_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= RX_IDLE;
            sh    <= '1;
            smp_q <= 1'b1;
            flag  <= 1'b0;
            data  <= '0;
        end else begin
            if (flag_clr)
                flag <= 1'b0;
            case (st)
                RX_IDLE: begin
                    if (enable && !flag && !tx_busy && !tx_req)
                        st <= RX_REQ;
                end
                RX_REQ: begin
                    if (s1p1)
                        st <= RX_ARM;
                end
                RX_ARM: begin
                    if (s6p2) begin
                        sh <= {{(W-1){1'b1}}, 1'b0};
                        st <= RX_LOADED;
                    end
                end
                RX_LOADED: begin
                    if (s1p1)
                        st <= RX_RUN;
                end
                RX_RUN: begin
                    if (s5p2)
                        smp_q <= din;
                    if (s6p2) begin
                        sh <= shifted;
                        if (!sh[W-1]) begin
                            data <= bit_reverse(shifted);
                            st   <= RX_FINISH;
                        end
                    end
                end
                RX_FINISH: begin
                    if (s1p1) begin
                        flag <= 1'b1;
                        st   <= RX_IDLE;
                    end
                end
                default: st <= RX_IDLE;
            endcase
        end
    end

    assign receiving = (st == RX_RUN) || (st == RX_FINISH);
    assign busy      = (st != RX_IDLE);

    // R8
    rx_flag_s1p1_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(s1p1));

    // R9
    rx_flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(flag) |-> $past(flag_clr));

    // R10
    rx_start_flag_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(receiving) |-> !flag);

endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port
    import sp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fast_mode,
    input  logic              buf_wr,
    input  logic [DATA_W-1:0] buf_wdata,
    input  logic              rx_en,
    input  logic              tx_flag_clr,
    input  logic              rx_flag_clr,
    input  logic              data_i,
    output logic              data_o,
    output logic              data_oe,
    output logic              sclk_o,
    output logic              tx_flag,
    output logic              rx_flag,
    output logic [DATA_W-1:0] rx_data
);

    strobes_t ev;
    logic     tx_sending, tx_busy, tx_line;
    logic     rx_receiving, rx_busy;

    sp_timebase u_tb (
        .clk  (clk),
        .rst  (rst),
        .fast (fast_mode),
        .ev   (ev)
    );

    sp_tx #(.W(DATA_W)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .s1p1     (ev.s1p1),
        .s6p2     (ev.s6p2),
        .wr       (buf_wr),
        .wr_data  (buf_wdata),
        .rx_busy  (rx_busy),
        .flag_clr (tx_flag_clr),
        .sending  (tx_sending),
        .line     (tx_line),
        .busy     (tx_busy),
        .flag     (tx_flag)
    );

    sp_rx #(.W(DATA_W)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .s1p1      (ev.s1p1),
        .s5p2      (ev.s5p2),
        .s6p2      (ev.s6p2),
        .enable    (rx_en),
        .din       (data_i),
        .tx_busy   (tx_busy),
        .tx_req    (buf_wr),
        .flag_clr  (rx_flag_clr),
        .receiving (rx_receiving),
        .busy      (rx_busy),
        .flag      (rx_flag),
        .data      (rx_data)
    );

    assign data_o  = tx_line;
    assign data_oe = !rx_receiving;
    assign sclk_o  = (tx_sending || rx_receiving) ? !ev.clk_low : 1'b1;

    // R5
    sclk_edge_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sclk_o) |-> (ev.s3p1 || ev.s6p1));

    // R6
    half_duplex_chk: assert property (@(posedge clk) disable iff (rst)
        !(tx_sending && rx_receiving));

endmodule

// File: tb/tb_sync_shift_port.sv
module tb_sync_shift_port;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fast_mode = 1'b0;
    logic       buf_wr = 1'b0;
    logic [7:0] buf_wdata = '0;
    logic       rx_en = 1'b0;
    logic       tx_flag_clr = 1'b0;
    logic       rx_flag_clr = 1'b0;
    logic       data_i = 1'b1;
    logic       data_o, data_oe, sclk_o, tx_flag, rx_flag;
    logic [7:0] rx_data;

    int checks = 0;
    int fails  = 0;
    int nxt    = 0;

    always #4 clk = ~clk;

    sync_shift_port dut (
        .clk(clk), .rst(rst), .fast_mode(fast_mode),
        .buf_wr(buf_wr), .buf_wdata(buf_wdata), .rx_en(rx_en),
        .tx_flag_clr(tx_flag_clr), .rx_flag_clr(rx_flag_clr),
        .data_i(data_i), .data_o(data_o), .data_oe(data_oe),
        .sclk_o(sclk_o), .tx_flag(tx_flag), .rx_flag(rx_flag),
        .rx_data(rx_data)
    );

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // R2: phase stepping model
    function automatic int adv(int n, logic f);
        if (f) return ((n & ~1) + 2) % 12;
        return (n + 1) % 12;
    endfunction

    // edges from the write/start edge to state 1 phase 1 of cycle 10
    function automatic int eoff(logic f, int p);
        if (f) return (12 - p) / 2 + 54;
        return (12 - p) + 108;
    endfunction

    task automatic tick();
        @(negedge clk);
        nxt = adv(nxt, fast_mode);
    endtask

    task automatic do_reset(input logic f);
        @(negedge clk);
        rst = 1'b1; fast_mode = f; buf_wr = 0; rx_en = 0;
        tx_flag_clr = 0; rx_flag_clr = 0; data_i = 1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        nxt = 0;
    endtask

    task automatic wait_phase(input int p);
        while (nxt != p) tick();
    endtask

    task automatic test_reset();
        do_reset(1'b0);
        check_eq("R1", "sclk_o", sclk_o, 1);
        check_eq("R1", "data_o", data_o, 1);
        check_eq("R1", "data_oe", data_oe, 1);
        check_eq("R1", "tx_flag", tx_flag, 0);
        check_eq("R1", "rx_flag", rx_flag, 0);
        check_eq("R1", "rx_data", rx_data, 0);
    endtask

    task automatic test_tx(input logic f, input int p, input logic [7:0] d,
                           input logic extra, input logic [7:0] d2);
        logic [7:0] bits = '0;
        int  n = 0, lows = 0, badph = 0, lim;
        logic prev;
        int e = eoff(f, p);
        do_reset(f);
        wait_phase(p);
        buf_wr = 1'b1; buf_wdata = d;
        prev = sclk_o;
        lim = e + 13;
        for (int j = 1; j <= lim; j++) begin
            if (j == 30 && extra) begin buf_wr = 1'b1; buf_wdata = d2; end
            tick();
            buf_wr = 1'b0;
            if (!prev && sclk_o) begin
                if (n < 8) bits[n] = data_o;
                n++;
            end
            if (!sclk_o) begin
                lows++;
                if (nxt < 4 || nxt > 9) badph++;
            end
            prev = sclk_o;
            if (j == e)     check_eq("R4", "tx_flag before S1P1 of cycle 10", tx_flag, 0);
            if (j == e + 1) check_eq("R4", "tx_flag at S1P1 of cycle 10", tx_flag, 1);
        end
        check_eq("R3", "rising sclk edges", n, 8);
        check_eq("R3", "bits at rising edges", bits, d);
        check_eq("R5", "low sclk samples", lows, f ? 24 : 48);
        check_eq("R5", "low samples outside states 3-5", badph, 0);
        check_eq("R5", "idle data_o", data_o, 1);
        check_eq("R5", "idle sclk_o", sclk_o, 1);
        check_eq("R9", "tx_flag held without clear", tx_flag, 1);
        if (extra) begin
            // R6: the ignored write must not produce a second frame
            for (int j = 0; j < 150; j++) begin
                tick();
                if (!sclk_o) lows++;
            end
            check_eq("R6", "sclk lows after write during transmit", lows, f ? 24 : 48);
        end
        tx_flag_clr = 1'b1;
        tick();
        tx_flag_clr = 1'b0;
        check_eq("R9", "tx_flag after clear", tx_flag, 0);
    endtask

    task automatic test_rx(input logic f, input int p, input logic [7:0] d,
                           input logic first, input logic wr_during);
        int n = 0, oe_bad = 0, lim;
        logic prev;
        int e = eoff(f, p);
        if (first) do_reset(f);
        wait_phase(p);
        if (first) rx_en = 1'b1; else rx_flag_clr = 1'b1;
        prev = sclk_o;
        lim = e + 40;
        for (int j = 1; j <= lim; j++) begin
            if (j == 40 && wr_during) begin buf_wr = 1'b1; buf_wdata = 8'h5A; end
            tick();
            rx_flag_clr = 1'b0;
            buf_wr = 1'b0;
            if (prev && !sclk_o) begin
                data_i = (n < 8) ? d[n] : 1'b1;
                n++;
            end
            if (!sclk_o && data_oe) oe_bad++;
            prev = sclk_o;
            if (j == e)     check_eq("R8", "rx_flag before S1P1 of cycle 10", rx_flag, 0);
            if (j == e + 1) begin
                check_eq("R8", "rx_flag at S1P1 of cycle 10", rx_flag, 1);
                check_eq("R8", "rx_data", rx_data, d);
            end
        end
        check_eq("R7", "data_oe high during receive", oe_bad, 0);
        check_eq("R10", "falling sclk edges with flag set", n, 8);
        check_eq("R7", "data_oe after receive", data_oe, 1);
        if (wr_during) begin
            check_eq("R6", "tx_flag after write during receive", tx_flag, 0);
            check_eq("R6", "data_o after write during receive", data_o, 1);
        end
    endtask

    initial begin
        #(8 * 100000);
        fails++;
        $display("FAIL R4 watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        test_reset();
        test_tx(1'b0, 5, 8'hA5, 1'b0, 8'h00);
        test_tx(1'b0, 11, 8'h01, 1'b1, 8'hFF);
        test_tx(1'b1, 4, 8'h3C, 1'b0, 8'h00);
        test_rx(1'b0, 3, 8'hC9, 1'b1, 1'b0);
        test_rx(1'b0, 7, 8'h6E, 1'b0, 1'b1);
        test_rx(1'b1, 2, 8'h81, 1'b1, 1'b0);
        test_rx(1'b1, 6, 8'h17, 1'b0, 1'b0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule